// File: doc/BRIEF.md
# SD Card Clock Prescaler and Divider

This block derives the SD card clock from a base clock through two cascaded division stages: a power-of-two prescaler and a linear divisor of 1 to 16. Both stages and three clock-enable bits sit in one control word. Software loads this word through a single-cycle write port. The block emits a divided SD clock, a flag that rises once that clock has run steadily for two full periods, and the three enable levels for the interface, host and peripheral clock domains.

Software programs the fields directly; it does not ask for a target frequency. To retune, it writes a word with every enable bit clear, then writes the new divider values with the enables set. A divider change written while the clock runs is held back until the current output period has finished, so a change never produces a shortened pulse. The total division ratio is the product of the two stages. Odd ratios give a high phase one base cycle shorter than the low phase.

Top module: `sdclk_gen`

## Requirements
- R1: When `wr_en_i` is high at a rising edge of `clk_i`, the control word `wr_data_i` is captured on that edge. From the next cycle, `if_clk_en_o`, `host_clk_en_o` and `per_clk_en_o` show word bits 0, 1 and 2.
- R2: Word bits 15:8 are the prescale code. A code of zero gives a factor of 1. Any other code gives 2 to the power (index of its highest set bit + 1). So 0x01 gives 2, 0x03 gives 4 and 0x80 gives 256.
- R3: Word bits 7:4 hold the divisor minus one, so the divisor runs from 1 (field 0) to 16 (field 15).
- R4: While running, one SD clock period lasts N base cycles, where N is the prescale factor times the divisor. A product of 1 is raised to N = 2.
- R5: Each period starts with a high phase of floor(N/2) base cycles, followed by a low phase of N - floor(N/2) base cycles.
- R6: The clock runs when any of word bits 2:0 is set. After a write that clears all three, `sd_clk_o` is low from the next rising edge onward.
- R7: A new divider setting written while the clock runs takes effect at the start of the next output period. The phase in progress completes at its old length.
- R8: After a write that enables the clock from the idle state, `sd_clk_o` rises on the following edge. `clk_stable_o` rises 2N base cycles after that first rising edge.
- R9: Any write clears `clk_stable_o` on its capture edge. The flag stays low while all enable bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word |
| sd_clk_o | output | 1 | Divided SD clock |
| clk_stable_o | output | 1 | SD clock has run steadily for two periods |
| if_clk_en_o | output | 1 | Interface clock enable (word bit 0) |
| host_clk_en_o | output | 1 | Host clock enable (word bit 1) |
| per_clk_en_o | output | 1 | Peripheral clock enable (word bit 2) |

## Verification
The bench checks these corners:
- The clamped ratio of 1. A design that let it through would hold the clock low.
- Odd ratios. A flipped duty split would show a long high phase.
- Multi-bit prescale codes. A design that decoded the lowest set bit would run too fast.
- The deepest setting of 256 by 16, which catches counter overflow.
- A live divider write landing in the middle of a high phase. A design that switched at once would cut that phase short.
- The stable flag, counted to the exact cycle. A design that counted the starting edge as a finished period would raise the flag one period early.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Power-of-two prescale factor from a code: highest set bit wins, zero bypasses.
  function automatic int unsigned prescale_of(input int unsigned code, input int unsigned code_w);
    int unsigned f;
    f = 1;
    for (int unsigned i = 0; i < code_w; i++) begin
      if (code[i]) f = 2 << i;
    end
    return f;
  endfunction

  // Total division ratio, with a floor of two base cycles per period.
  function automatic int unsigned ratio_of(input int unsigned code, input int unsigned code_w,
                                           input int unsigned div_field);
    int unsigned n;
    n = prescale_of(code, code_w) * (div_field + 1);
    return (n < 2) ? 2 : n;
  endfunction

  // High phase length: the shorter half for odd ratios.
  function automatic int unsigned high_of(input int unsigned n);
    return n / 2;
  endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg #(
  parameter int DATA_W  = 32,
  parameter int PRE_LSB = 8,
  parameter int PRE_W   = 8,
  parameter int DIV_LSB = 4,
  parameter int DIV_W   = 4,
  parameter int ENA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PRE_W-1:0]  pre_code_o,
  output logic [DIV_W-1:0]  div_code_o,
  output logic [ENA_W-1:0]  ena_o
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [ENA_W-1:0] ena_q;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
      ena_q <= '0;
    end else if (wr_en_i) begin
      pre_q <= wr_data_i[PRE_LSB +: PRE_W];
      div_q <= wr_data_i[DIV_LSB +: DIV_W];
      ena_q <= wr_data_i[ENA_W-1:0];
    end
  end

  assign pre_code_o = pre_q;
  assign div_code_o = div_q;
  assign ena_o      = ena_q;

  AST_ENA_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ena_o == $past(wr_data_i[ENA_W-1:0]))) else $error("enable capture"); // R1
endmodule

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
  parameter int PRE_W   = 8,
  parameter int DIV_W   = 4,
  parameter int RATIO_W = PRE_W + DIV_W + 1
) (
  input  logic [PRE_W-1:0]   pre_code_i,
  input  logic [DIV_W-1:0]   div_code_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [RATIO_W-1:0] high_len_o
);
  int unsigned ratio_int;

  always_comb begin
    ratio_int  = sdclk_pkg::ratio_of(32'(pre_code_i), PRE_W, 32'(div_code_i));
    ratio_o    = RATIO_W'(ratio_int);
    high_len_o = RATIO_W'(sdclk_pkg::high_of(ratio_int));
  end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
  parameter int RATIO_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic [RATIO_W-1:0] cfg_high_i,
  output logic               sd_clk_o,
  output logic               wrap_o
);
  logic [RATIO_W-1:0] cnt_q, act_n_q, act_h_q;
  logic               sd_q;
  logic               period_end;

  assign period_end = run_i && (cnt_q == act_n_q - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= RATIO_W'(1);
      act_n_q <= RATIO_W'(2);
      act_h_q <= RATIO_W'(1);
      sd_q    <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= cfg_ratio_i - RATIO_W'(1);
      act_n_q <= cfg_ratio_i;
      act_h_q <= cfg_high_i;
      sd_q    <= 1'b0;
    end else if (period_end) begin
      cnt_q   <= '0;
      act_n_q <= cfg_ratio_i;
      act_h_q <= cfg_high_i;
      sd_q    <= (cfg_high_i != '0);
    end else begin
      cnt_q   <= cnt_q + RATIO_W'(1);
      sd_q    <= ((cnt_q + RATIO_W'(1)) < act_h_q);
    end
  end

  assign sd_clk_o = sd_q;
  assign wrap_o   = period_end;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sd_clk_o) else $error("clock not low while idle"); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_n_q) else $error("counter beyond period"); // R4
  AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !period_end) |=> ($stable(act_n_q) && $stable(act_h_q))) else $error("mid-period switch"); // R7
  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_q) |-> (cnt_q == '0)) else $error("rise off period start"); // R5
endmodule

// File: rtl/sdclk_lock_mon.sv
module sdclk_lock_mon #(
  parameter int LOCK_PERIODS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wr_ev_i,
  input  logic wrap_i,
  output logic stable_o
);
  localparam int CW = $clog2(LOCK_PERIODS + 2);

  logic [CW-1:0] starts_q;
  logic          stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      starts_q <= '0;
      stable_q <= 1'b0;
    end else if (!run_i || wr_ev_i) begin
      starts_q <= '0;
      stable_q <= 1'b0;
    end else if (wrap_i && !stable_q) begin
      if (starts_q == CW'(LOCK_PERIODS)) stable_q <= 1'b1;
      else starts_q <= starts_q + CW'(1);
    end
  end

  assign stable_o = stable_q;

  AST_WRITE_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ev_i |=> !stable_o) else $error("stable kept over write"); // R9
  AST_IDLE_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !stable_o) else $error("stable while idle"); // R9
  AST_LOCK_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> $past(wrap_i)) else $error("stable off boundary"); // R8
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int DATA_W       = 32,
  parameter int PRE_LSB      = 8,
  parameter int PRE_W        = 8,
  parameter int DIV_LSB      = 4,
  parameter int DIV_W        = 4,
  parameter int LOCK_PERIODS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sd_clk_o,
  output logic              clk_stable_o,
  output logic              if_clk_en_o,
  output logic              host_clk_en_o,
  output logic              per_clk_en_o
);
  localparam int ENA_W   = 3;
  localparam int RATIO_W = PRE_W + DIV_W + 1;

  logic [PRE_W-1:0]   pre_code;
  logic [DIV_W-1:0]   div_code;
  logic [ENA_W-1:0]   ena;
  logic [RATIO_W-1:0] cfg_ratio, cfg_high;
  logic               run, wrap;

  sdclk_ctrl_reg #(
    .DATA_W(DATA_W), .PRE_LSB(PRE_LSB), .PRE_W(PRE_W),
    .DIV_LSB(DIV_LSB), .DIV_W(DIV_W), .ENA_W(ENA_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .pre_code_o(pre_code), .div_code_o(div_code), .ena_o(ena)
  );

  sdclk_ratio #(.PRE_W(PRE_W), .DIV_W(DIV_W), .RATIO_W(RATIO_W)) u_ratio (
    .pre_code_i(pre_code), .div_code_i(div_code),
    .ratio_o(cfg_ratio), .high_len_o(cfg_high)
  );

  assign run = |ena;

  sdclk_phase_gen #(.RATIO_W(RATIO_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .cfg_ratio_i(cfg_ratio), .cfg_high_i(cfg_high),
    .sd_clk_o(sd_clk_o), .wrap_o(wrap)
  );

  sdclk_lock_mon #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .wr_ev_i(wr_en_i),
    .wrap_i(wrap), .stable_o(clk_stable_o)
  );

  assign if_clk_en_o   = ena[0];
  assign host_clk_en_o = ena[1];
  assign per_clk_en_o  = ena[2];

  AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ratio >= RATIO_W'(2)) && ((cfg_high << 1) <= cfg_ratio)) else $error("ratio floor"); // R4
  AST_ZERO_CODE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pre_code == '0) && (div_code != '0)) |-> (cfg_ratio == RATIO_W'(div_code) + RATIO_W'(1))) else $error("bypass"); // R2
endmodule

// File: tb/sdclk_gen_tb_top.sv
module sdclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sd_clk, stable, en_if, en_host, en_per;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  sdclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sd_clk_o(sd_clk), .clk_stable_o(stable),
    .if_clk_en_o(en_if), .host_clk_en_o(en_host), .per_clk_en_o(en_per)
  );

  // Factor by repeated halving of the code: bit k highest -> 2^(k+1).
  function automatic int exp_ratio(input int code, input int dfield);
    int p, c;
    p = 1;
    c = code;
    while (c != 0) begin
      p = p * 2;
      c = c >> 1;
    end
    return (p * (dfield + 1) < 2) ? 2 : p * (dfield + 1);
  endfunction

  function automatic logic [31:0] word(input int code, input int dfield, input logic [2:0] en);
    return {16'h0, code[7:0], dfield[3:0], 1'b0, en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Sync to a rising edge, then measure one high and one low phase.
  task automatic measure(output int hi, output int lo);
    logic prev;
    int   guard;
    hi = -1;
    lo = -1;
    prev = sd_clk;
    guard = 0;
    @(negedge clk);
    while (!(prev == 1'b0 && sd_clk == 1'b1) && guard < 20000) begin
      prev = sd_clk;
      guard++;
      @(negedge clk);
    end
    if (guard >= 20000) return;
    hi = 0;
    while (sd_clk && guard < 20000) begin hi++; guard++; @(negedge clk); end
    lo = 0;
    while (!sd_clk && guard < 20000) begin lo++; guard++; @(negedge clk); end
  endtask

  task automatic run_case(input int code, input int dfield, input string tag);
    int n, k, hi, lo;
    n = exp_ratio(code, dfield);
    wr(32'h0);
    chk(stable == 1'b0, {"R9 ", tag}, stable, 0);
    wr(word(code, dfield, 3'b111));
    k = 0;
    while (!stable && k < 20000) begin @(negedge clk); k++; end
    chk(k == 2 * n + 1, {"R8 ", tag}, k, 2 * n + 1);
    measure(hi, lo);
    chk(hi == n / 2, {"R5 ", tag}, hi, n / 2);
    chk(hi + lo == n, {"R4 ", tag}, hi + lo, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, ones, code, dfield;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sd_clk == 1'b0 && stable == 1'b0, "R6 reset idle", {sd_clk, stable}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enable bits appear on the outputs
    wr(word(1, 0, 3'b010));
    chk({en_per, en_host, en_if} == 3'b010, "R1 host only", {en_per, en_host, en_if}, 2);
    wr(word(1, 0, 3'b101));
    chk({en_per, en_host, en_if} == 3'b101, "R1 per+if", {en_per, en_host, en_if}, 5);

    // R2 R3 R4 R5 directed corners
    run_case(8'h00, 0, "clamp ratio 1 to 2");
    run_case(8'h00, 2, "odd ratio 3");
    run_case(8'h01, 0, "code 0x01 factor 2");
    run_case(8'h03, 1, "R2 multi-bit code 0x03");
    run_case(8'h00, 15, "R3 divisor 16 bypass");
    run_case(8'h80, 15, "deepest 256x16");

    // Random settings
    for (int i = 0; i < 12; i++) begin
      code = int'($urandom % 32);
      dfield = int'($urandom % 16);
      run_case(code, dfield, "random");
    end

    // R7: live change written in the middle of a high phase
    run_case(8'h01, 2, "R7 setup N=6");
    begin
      logic prev;
      int   guard;
      prev = sd_clk;
      guard = 0;
      @(negedge clk);
      while (!(prev == 1'b0 && sd_clk == 1'b1) && guard < 100) begin
        prev = sd_clk; guard++; @(negedge clk);
      end
      wr_en = 1'b1;
      wr_data = word(8'h00, 4, 3'b001);
      hi = 1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(stable == 1'b0, "R9 live write clears stable", stable, 0);
      while (sd_clk && hi < 100) begin hi++; @(negedge clk); end
      lo = 0;
      while (!sd_clk && lo < 100) begin lo++; @(negedge clk); end
      chk(hi == 3, "R7 old high phase kept", hi, 3);
      chk(lo == 3, "R7 old low phase kept", lo, 3);
      measure(hi, lo);
      chk(hi == 2, "R7 new high phase", hi, 2);
      chk(lo == 3, "R7 new low phase", lo, 3);
    end

    // R6: disable holds the clock low
    wr(32'h0);
    ones = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      ones += int'(sd_clk) + int'(stable);
    end
    chk(ones == 0, "R6 disabled clock low", ones, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule